// File: doc/BRIEF.md
# Scan-List ADC Sequencer with Result FIFO

This block runs one conversion cycle of an eight-channel analog front end whose inputs are all sampled together. The host writes a channel mask with one bit per input. A conversion is begun either by a host software start strobe or by a hardware trigger. The hardware trigger is a falling edge on one of two sources, the external trigger pin or a companion timer output, chosen by a single select input. The analog converter is outside the block and appears only as ports.

Once started, the block copies the mask, empties its result FIFO and raises the active-low end-of-conversion flag. It issues one sample command for all channels. It then asks for one converted value per enabled channel, lowest channel first, and waits for a valid handshake each time. Every accepted value is pushed into the FIFO. When the number of handshakes equals the number of set mask bits, the flag drops low and stays low until the next start. Host reads pop the FIFO one or two results at a time. Results are 14-bit two's complement values returned in 16-bit halves whose top two bits are zero.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `eoc_n` is 0, `conv_sample` and `conv_req` are 0, and `rd_data` is zero because the FIFO is empty.
- R2: A start accepted at a clock edge makes `conv_sample` high for exactly the one following cycle. `conv_req` follows in the cycle after that.
- R3: With `trig_sel`=0, a falling edge on `ext_trig` starts a conversion. With `trig_sel`=1, a falling edge on `tmr_out` starts one. Rising edges, and edges on the source that is not selected, start nothing.
- R4: Mask bit i (bits 0 to 7) enables channel i. `conv_chan` presents the enabled channels in ascending order and holds each one until `conv_valid` is accepted with `conv_req` high.
- R5: `eoc_n` goes high with the sample command and stays high while the scan runs. It goes low in the cycle after the last handshake and stays low until the next accepted start.
- R6: A single read (`rd_en`=1, `rd_dual`=0) returns the oldest result in `rd_data[13:0]`, with `rd_data[31:14]` zero, and pops one entry. Results come out lowest channel first.
- R7: A dual read (`rd_en`=1, `rd_dual`=1) returns the oldest result in bits 13:0 and the next one in bits 29:16, and pops both. If only one entry is present, bits 31:16 read zero and one entry is popped.
- R8: Every accepted start empties the FIFO of any earlier results.
- R9: A start strobe or trigger edge that arrives while a scan is running is ignored.
- R10: A mask write during a running scan does not change the channels of that scan. It takes effect at the next start.
- R11: A start with an all-zero mask issues no sample command and no request, leaves `eoc_n` low, and leaves the FIFO empty.
- R12: Reading an empty FIFO returns zero and does not change the FIFO contents or pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_wr | input | 1 | Write strobe for the channel mask |
| mask_wdata | input | 8 | Channel mask, bit i enables channel i |
| start_rd | input | 1 | Software start strobe (host read of the start address) |
| trig_sel | input | 1 | Hardware trigger source: 0 external pin, 1 timer output |
| ext_trig | input | 1 | External trigger input, falling-edge active |
| tmr_out | input | 1 | Companion timer output, falling-edge active |
| rd_en | input | 1 | Host read of the result FIFO; pops at the clock edge |
| rd_dual | input | 1 | Wide read: fetch and pop two results |
| rd_data | output | 32 | Read data: oldest result in bits 15:0, next result in bits 31:16 |
| conv_sample | output | 1 | One-cycle command to sample all channels |
| conv_req | output | 1 | Request for the converted value of `conv_chan` |
| conv_chan | output | 3 | Channel whose value is requested |
| conv_valid | input | 1 | Converter handshake: `conv_data` holds the requested value |
| conv_data | input | 14 | Converted value, two's complement |
| eoc_n | output | 1 | End of conversion, active low; high while a scan runs |

## Verification
The assertions assume the converter raises `conv_valid` only while `conv_req` is high, and that it keeps `conv_data` steady for the cycle in which the handshake is taken. The bench's converter model holds to this. It looks at `conv_req` and `conv_chan` only at the falling clock edge, waits a chosen number of cycles, and then offers exactly one value for the channel shown. It drops `conv_valid` once `conv_req` goes away. Trigger inputs, strobes and reads are all changed at the falling edge, so every start and pop lands on a clean rising edge.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int unsigned CHAN_COUNT = 8;
    localparam int unsigned SAMPLE_W   = 14;
    localparam int unsigned HALF_W     = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SAMPLE = 2'd1,
        SEQ_SCAN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } host_word_t;

    // Keep only the low dw bits of a half word; the bits above read zero.
    function automatic logic [HALF_W-1:0] clip_half(input logic [HALF_W-1:0] v, input int dw);
        logic [HALF_W-1:0] keep;
        keep = (HALF_W'(1) << dw) - HALF_W'(1);
        return v & keep;
    endfunction

endpackage

// File: rtl/adc_start_sel.sv
module adc_start_sel (
    input  logic clk,
    input  logic rst,
    input  logic sw_start,
    input  logic trig_sel,
    input  logic ext_trig,
    input  logic tmr_out,
    output logic start_req
);
    logic ext_q;
    logic tmr_q;
    logic ext_fall;
    logic tmr_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
            tmr_q <= 1'b0;
        end else begin
            ext_q <= ext_trig;
            tmr_q <= tmr_out;
        end
    end

    assign ext_fall  = ext_q & ~ext_trig;
    assign tmr_fall  = tmr_q & ~tmr_out;
    assign start_req = sw_start | (trig_sel ? tmr_fall : ext_fall);

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    input  logic                       pop_two,
    output logic [DW-1:0]              head0,
    output logic [DW-1:0]              head1,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic [1:0]    n_pop;
    logic          push_ok;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int n);
        int t;
        t = int'(p) + n;
        if (t >= DEPTH) t = t - DEPTH;
        return PW'(t);
    endfunction

    always_comb begin
        n_pop = 2'd0;
        if (pop) begin
            if (pop_two && count >= CW'(2)) n_pop = 2'd2;
            else if (count != '0)           n_pop = 2'd1;
        end
    end

    assign push_ok = push && (count < CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= adv(wr_ptr, 1);
            rd_ptr <= adv(rd_ptr, int'(n_pop));
            count  <= count + CW'(push_ok) - CW'(n_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush && !rst) mem[wr_ptr] <= push_data;
    end

    assign head0 = mem[rd_ptr];
    assign head1 = mem[adv(rd_ptr, 1)];
    assign level = count;

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_req,
    input  logic [NCH-1:0]           mask_in,
    input  logic                     conv_valid,
    output logic                     sample_o,
    output logic                     req_o,
    output logic [$clog2(NCH)-1:0]   chan_o,
    output logic                     push_o,
    output logic                     flush_o,
    output logic                     eoc_n_o,
    output logic [NCH-1:0]           pend_o,
    output logic [$clog2(NCH+1)-1:0] left_o
);
    localparam int AW = $clog2(NCH);
    localparam int CW = $clog2(NCH + 1);

    seq_state_e     state;
    logic [NCH-1:0] pend;
    logic [CW-1:0]  left;
    logic           eoc_n;
    logic           hit;
    logic [NCH-1:0] low_bit;
    logic [CW-1:0]  mask_pop;

    always_comb begin
        chan_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) chan_o = AW'(i);
        end
    end

    always_comb begin
        mask_pop = '0;
        for (int i = 0; i < NCH; i++) mask_pop = mask_pop + CW'(mask_in[i]);
    end

    assign low_bit  = pend & (~pend + NCH'(1));
    assign sample_o = (state == SEQ_SAMPLE);
    assign req_o    = (state == SEQ_SCAN);
    assign hit      = req_o & conv_valid;
    assign push_o   = hit;
    assign flush_o  = start_req & (state == SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            pend  <= '0;
            left  <= '0;
            eoc_n <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start_req) begin
                        pend <= mask_in;
                        left <= mask_pop;
                        if (mask_in != '0) begin
                            state <= SEQ_SAMPLE;
                            eoc_n <= 1'b1;
                        end
                    end
                end
                SEQ_SAMPLE: state <= SEQ_SCAN;
                SEQ_SCAN: begin
                    if (hit) begin
                        pend <= pend & ~low_bit;
                        left <= left - CW'(1);
                        if (left == CW'(1)) begin
                            state <= SEQ_IDLE;
                            eoc_n <= 1'b0;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign eoc_n_o = eoc_n;
    assign pend_o  = pend;
    assign left_o  = left;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH = CHAN_COUNT,
    parameter int DW  = SAMPLE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mask_wr,
    input  logic [NCH-1:0]         mask_wdata,
    input  logic                   start_rd,
    input  logic                   trig_sel,
    input  logic                   ext_trig,
    input  logic                   tmr_out,
    input  logic                   rd_en,
    input  logic                   rd_dual,
    output logic [2*HALF_W-1:0]    rd_data,
    output logic                   conv_sample,
    output logic                   conv_req,
    output logic [$clog2(NCH)-1:0] conv_chan,
    input  logic                   conv_valid,
    input  logic [DW-1:0]          conv_data,
    output logic                   eoc_n
);
    localparam int CW = $clog2(NCH + 1);

    logic [NCH-1:0] mask_q;
    logic           start_req;
    logic           push;
    logic           flush;
    logic [NCH-1:0] pend_mask;
    logic [CW-1:0]  left_cnt;
    logic [DW-1:0]  head0;
    logic [DW-1:0]  head1;
    logic [CW-1:0]  fifo_level;
    host_word_t     word;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    adc_start_sel u_start (
        .clk       (clk),
        .rst       (rst),
        .sw_start  (start_rd),
        .trig_sel  (trig_sel),
        .ext_trig  (ext_trig),
        .tmr_out   (tmr_out),
        .start_req (start_req)
    );

    adc_scan_ctrl #(.NCH(NCH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .mask_in    (mask_q),
        .conv_valid (conv_valid),
        .sample_o   (conv_sample),
        .req_o      (conv_req),
        .chan_o     (conv_chan),
        .push_o     (push),
        .flush_o    (flush),
        .eoc_n_o    (eoc_n),
        .pend_o     (pend_mask),
        .left_o     (left_cnt)
    );

    adc_result_fifo #(.DEPTH(NCH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .push_data (conv_data),
        .pop       (rd_en),
        .pop_two   (rd_dual),
        .head0     (head0),
        .head1     (head1),
        .level     (fifo_level)
    );

    always_comb begin
        word = '0;
        if (fifo_level != '0)
            word.lo = clip_half(HALF_W'(head0), DW);
        if (rd_dual && fifo_level >= CW'(2))
            word.hi = clip_half(HALF_W'(head1), DW);
    end

    assign rd_data = word;

endmodule

module adc_scan_seq_chk #(
    parameter int NCH = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     sample,
    input logic                     req,
    input logic                     valid,
    input logic [$clog2(NCH)-1:0]   chan,
    input logic                     eoc_n,
    input logic [NCH-1:0]           pend,
    input logic [$clog2(NCH+1)-1:0] left,
    input logic [$clog2(NCH+1)-1:0] level
);
    // R2
    sample_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        sample |=> (!sample && req));

    // R5
    busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> eoc_n);

    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc_n) |-> sample);

    // R4
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !valid) |=> (req && $stable(chan)));

    // R4
    count_match_chk: assert property (@(posedge clk) disable iff (rst)
        int'(left) == $countones(pend));

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= NCH);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .sample(conv_sample),
    .req   (conv_req),
    .valid (conv_valid),
    .chan  (conv_chan),
    .eoc_n (eoc_n),
    .pend  (pend_mask),
    .left  (left_cnt),
    .level (fifo_level)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        mask_wr;
    logic [7:0]  mask_wdata;
    logic        start_rd;
    logic        trig_sel;
    logic        ext_trig;
    logic        tmr_out;
    logic        rd_en;
    logic        rd_dual;
    logic [31:0] rd_data;
    logic        conv_sample;
    logic        conv_req;
    logic [2:0]  conv_chan;
    logic        conv_valid;
    logic [13:0] conv_data;
    logic        eoc_n;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    int lat = 0;
    int seed = 0;
    int wc = 0;
    int acc_cnt = 0;
    logic [2:0] acc_chan [16];

    always #4 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst(rst), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .start_rd(start_rd), .trig_sel(trig_sel), .ext_trig(ext_trig),
        .tmr_out(tmr_out), .rd_en(rd_en), .rd_dual(rd_dual), .rd_data(rd_data),
        .conv_sample(conv_sample), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_valid(conv_valid), .conv_data(conv_data), .eoc_n(eoc_n)
    );

    function automatic logic [13:0] data_of(input int ch, input int s);
        return 14'((s * 1031 + ch * 2053 + 8192) % 16384);
    endfunction

    // Converter model: offers one value per requested channel after lat idle cycles.
    initial begin
        conv_valid = 1'b0;
        conv_data  = '0;
        forever begin
            @(negedge clk);
            if (conv_req) begin
                if (wc >= lat) begin
                    if (acc_cnt < 16) acc_chan[acc_cnt] = conv_chan;
                    acc_cnt++;
                    conv_valid = 1'b1;
                    conv_data  = data_of(int'(conv_chan), seed);
                    wc = 0;
                end else begin
                    conv_valid = 1'b0;
                    wc++;
                end
            end else begin
                conv_valid = 1'b0;
                wc = 0;
            end
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_mask(input logic [7:0] m);
        @(negedge clk);
        mask_wr = 1'b1;
        mask_wdata = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    // Ends at the falling edge right after the start edge.
    task automatic sw_start();
        @(negedge clk);
        start_rd = 1'b1;
        @(negedge clk);
        start_rd = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400; i++) begin
            if (!eoc_n) break;
            @(negedge clk);
        end
    endtask

    task automatic read_word(input bit dual, output logic [31:0] w);
        @(negedge clk);
        rd_en = 1'b1;
        rd_dual = dual;
        #1 w = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
        rd_dual = 1'b0;
    endtask

    task automatic run_scan(input logic [7:0] m, input int l, input int s);
        lat = l;
        seed = s;
        write_mask(m);
        acc_cnt = 0;
        sw_start();
        wait_done();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 eoc_n", {31'd0, eoc_n}, 32'd0);
        check_eq("R1 conv_sample", {31'd0, conv_sample}, 32'd0);
        check_eq("R1 conv_req", {31'd0, conv_req}, 32'd0);
        check_eq("R1 rd_data", rd_data, 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] w;
        int k;
        lat = 2;
        seed = 1;
        write_mask(8'hA5);
        acc_cnt = 0;
        sw_start();
        check_eq("R2 sample pulse", {31'd0, conv_sample}, 32'd1);
        check_eq("R5 flag high at start", {31'd0, eoc_n}, 32'd1);
        @(negedge clk);
        check_eq("R2 sample ends", {31'd0, conv_sample}, 32'd0);
        check_eq("R2 request follows", {31'd0, conv_req}, 32'd1);
        check_eq("R4 first channel", {29'd0, conv_chan}, 32'd0);
        wait_done();
        check_eq("R5 handshakes at done", acc_cnt, 32'd4);
        k = 0;
        for (int ch = 0; ch < 8; ch++) begin
            if (8'hA5 & (8'h1 << ch)) begin
                check_eq("R4 scan order", {29'd0, acc_chan[k]}, ch);
                k++;
            end
        end
        repeat (3) @(negedge clk);
        check_eq("R5 flag stays low", {31'd0, eoc_n}, 32'd0);
        for (int ch = 0; ch < 8; ch++) begin
            if (8'hA5 & (8'h1 << ch)) begin
                read_word(1'b0, w);
                check_eq("R6 single read", w, {18'd0, data_of(ch, 1)});
            end
        end
        read_word(1'b0, w);
        check_eq("R12 empty read", w, 32'd0);
    endtask

    task automatic t_dual();
        logic [31:0] w;
        run_scan(8'hFF, 0, 2);
        check_eq("R4 eight handshakes", acc_cnt, 32'd8);
        for (int k = 0; k < 4; k++) begin
            read_word(1'b1, w);
            check_eq("R7 dual read", w,
                     {2'b00, data_of(2 * k + 1, 2), 2'b00, data_of(2 * k, 2)});
        end
        read_word(1'b1, w);
        check_eq("R12 empty dual read", w, 32'd0);
        run_scan(8'h07, 1, 3);
        read_word(1'b1, w);
        check_eq("R7 dual read pair", w, {2'b00, data_of(1, 3), 2'b00, data_of(0, 3)});
        read_word(1'b1, w);
        check_eq("R7 dual read last one", w, {18'd0, data_of(2, 3)});
        read_word(1'b0, w);
        check_eq("R7 drained", w, 32'd0);
    endtask

    task automatic t_trigger();
        logic [31:0] w;
        lat = 0;
        seed = 4;
        write_mask(8'h02);
        trig_sel = 1'b0;
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk);
        check_eq("R3 rising ext ignored", {31'd0, conv_sample}, 32'd0);
        tmr_out = 1'b1;
        @(negedge clk); tmr_out = 1'b0;
        @(negedge clk);
        check_eq("R3 unselected timer ignored", {30'd0, conv_sample, eoc_n}, 32'd0);
        ext_trig = 1'b0;
        @(negedge clk);
        check_eq("R3 ext fall starts", {31'd0, conv_sample}, 32'd1);
        wait_done();
        read_word(1'b0, w);
        check_eq("R3 ext scan result", w, {18'd0, data_of(1, 4)});
        trig_sel = 1'b1;
        tmr_out = 1'b1;
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        @(negedge clk);
        check_eq("R3 unselected ext ignored", {30'd0, conv_sample, eoc_n}, 32'd0);
        seed = 5;
        tmr_out = 1'b0;
        @(negedge clk);
        check_eq("R3 timer fall starts", {31'd0, conv_sample}, 32'd1);
        wait_done();
        read_word(1'b0, w);
        check_eq("R3 timer scan result", w, {18'd0, data_of(1, 5)});
        trig_sel = 1'b0;
    endtask

    task automatic t_busy();
        logic [31:0] w;
        int samples;
        lat = 3;
        seed = 6;
        write_mask(8'h0C);
        acc_cnt = 0;
        sw_start();
        samples = 0;
        write_mask(8'hF0);
        @(negedge clk); start_rd = 1'b1;
        @(negedge clk); start_rd = 1'b0;
        if (conv_sample) samples++;
        check_eq("R9 busy start ignored", samples, 32'd0);
        wait_done();
        check_eq("R10 channel count", acc_cnt, 32'd2);
        check_eq("R10 first channel", {29'd0, acc_chan[0]}, 32'd2);
        check_eq("R10 second channel", {29'd0, acc_chan[1]}, 32'd3);
        read_word(1'b0, w);
        check_eq("R9 result ch2", w, {18'd0, data_of(2, 6)});
        read_word(1'b0, w);
        check_eq("R9 result ch3", w, {18'd0, data_of(3, 6)});
        read_word(1'b0, w);
        check_eq("R9 nothing extra", w, 32'd0);
    endtask

    task automatic t_flush();
        logic [31:0] w;
        run_scan(8'h30, 0, 7);
        run_scan(8'h40, 0, 8);
        read_word(1'b0, w);
        check_eq("R8 only new result", w, {18'd0, data_of(6, 8)});
        read_word(1'b0, w);
        check_eq("R8 old results flushed", w, 32'd0);
    endtask

    task automatic t_empty();
        logic [31:0] w;
        run_scan(8'h03, 0, 9);
        write_mask(8'h00);
        acc_cnt = 0;
        sw_start();
        check_eq("R11 no sample", {31'd0, conv_sample}, 32'd0);
        check_eq("R11 flag low", {31'd0, eoc_n}, 32'd0);
        @(negedge clk);
        check_eq("R11 no request", {31'd0, conv_req}, 32'd0);
        read_word(1'b0, w);
        check_eq("R11 FIFO emptied", w, 32'd0);
        read_word(1'b1, w);
        read_word(1'b0, w);
        check_eq("R12 repeated empty read", w, 32'd0);
        run_scan(8'h80, 2, 10);
        read_word(1'b0, w);
        check_eq("R12 FIFO intact after empty reads", w, {18'd0, data_of(7, 10)});
        read_word(1'b0, w);
        check_eq("R12 single entry", w, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        mask_wr = 1'b0;
        mask_wdata = '0;
        start_rd = 1'b0;
        trig_sel = 1'b0;
        ext_trig = 1'b0;
        tmr_out = 1'b0;
        rd_en = 1'b0;
        rd_dual = 1'b0;
        t_reset();
        t_basic();
        t_dual();
        t_trigger();
        t_busy();
        t_flush();
        t_empty();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule